// File: doc/BRIEF.md
# Port Pin Drive Sequencer with Boosted Rising Edge

This block controls the digital drive enables for a bank of microcontroller port pins that use a quasi-bidirectional output stage. Each pin has an output latch that software writes through a simple strobe interface. The block turns the latch into three pad-control enables: a strong sink, a strong source and a weak keeper.

A latch bit at 0 pulls the pad low hard. When a bit changes from 0 to 1, the strong source turns on for a short, fixed number of oscillator clock cycles so that the pad charges quickly. After that, only the weak keeper holds the pad high, so an outside device can still pull the line low.

Reads return the output latch or the synchronised pad level. The choice is made by a per-instance parameter. Output-only scan pins read back the latch, and general-purpose or mouse-style pins read back the pad. The boost length is also a per-instance parameter, since some pin groups use two oscillator periods and others use one.

Top module: `qbp_port`

## Requirements
- R1: While a latch bit is 0, that pin asserts `drv_low` and deasserts both `drv_high` and `keep_high`.
- R2: A write that changes a latch bit from 0 to 1 asserts `drv_high` on that pin for exactly `PULSE_LEN` clock cycles, starting in the cycle after the write edge. During those cycles `keep_high` is off.
- R3: Once the boost ends, a pin whose latch bit is 1 asserts only `keep_high`.
- R4: `PULSE_LEN` is set per instance. An instance with `PULSE_LEN` = 1 boosts for a single cycle.
- R5: Writing 1 to a latch bit that already holds 1 starts no boost. That pin stays on `keep_high` only.
- R6: Writing 0 to a pin during its boost ends the boost. In the next cycle the pin shows `drv_low` only.
- R7: Reset (`rst_n` low at a clock edge) sets every latch bit to 1. After reset is released, no pin asserts `drv_high` and every pin asserts `keep_high`.
- R8: With `READ_SRC` = latch (encoding 0), `rd_data` equals the output latch whenever `rd_en` is 1. `pad_in` has no effect on it.
- R9: With `READ_SRC` = pad (encoding 1), `rd_data` returns `pad_in` after two flip-flop stages. A pad change applied between clock edges appears after the second following rising edge.
- R10: While `rd_en` is 0, `rd_data` is all zeros.
- R11: On every pin, in every cycle, exactly one of `drv_low`, `drv_high` and `keep_high` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; boost length is counted in its periods |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the output latch |
| wr_data | input | WIDTH | New latch contents, bit i for pin i |
| rd_en | input | 1 | Read select; gates `rd_data` |
| pad_in | input | WIDTH | Raw pad levels, asynchronous to `clk` |
| rd_data | output | WIDTH | Latch or synchronised pad level, zero when not selected |
| drv_low | output | WIDTH | Strong pull-down enable per pin |
| drv_high | output | WIDTH | Strong pull-up enable per pin |
| keep_high | output | WIDTH | Weak pull-up enable per pin |

## Verification
Several properties are checked in every cycle. Each pin always has exactly one of its three enables active. A strong pull-up never lasts longer than `PULSE_LEN` cycles. A 0-to-1 write always starts a boost, and a write of 1 over 1 never does. No boost follows reset. Other behaviour can only be shown by the bench scenarios, because a single-cycle property cannot see it. This includes the exact start cycle and length of the boost for each pair of old and new latch values, the single-cycle boost of the second instance, and cutting a boost short with a 0 write. It also includes the two-edge pad latency and the fact that the latch-read variant ignores the pad.

// File: rtl/qbp_pkg.sv
// Shared definitions for the port drive sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package qbp_pkg;
    // Source returned on a port read.
    typedef enum logic {
        RD_LATCH = 1'b0,
        RD_PAD   = 1'b1
    } rd_src_e;
endpackage

// File: rtl/qbp_latch.sv
// Output latch for a bank of pins, plus detection of 0-to-1 bit changes.
// Assumes: a write takes effect on the rising edge where wr_en is high.
module qbp_latch #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] lat_q,
    output logic [WIDTH-1:0] rise_req,
    output logic [WIDTH-1:0] clr_req
);
    // Latch storage; reset leaves every pin released high.
    always_ff @(posedge clk) begin
        if (!rst_n)     lat_q <= '1;
        else if (wr_en) lat_q <= wr_data;
    end

    // Bits going from 0 to 1, and bits being written to 0, on this edge.
    always_comb begin
        rise_req = wr_en ? (wr_data & ~lat_q) : '0;
        clr_req  = wr_en ? ~wr_data : '0;
    end
endmodule

// File: rtl/qbp_boost.sv
// Per-pin timer that produces the strong pull-up window after a rising write.
// Assumes: PULSE_LEN >= 1; rise and clr are never both high.
module qbp_boost #(
    parameter int PULSE_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic clr,
    output logic boost
);
    localparam int CW = (PULSE_LEN < 2) ? 1 : $clog2(PULSE_LEN + 1);

    logic [CW-1:0] cnt;

    // Load on a rising write, cancel on a zero write, otherwise count down.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (rise)      cnt <= CW'(PULSE_LEN);
        else if (clr)       cnt <= '0;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    // The window stays open while cycles remain.
    assign boost = (cnt != '0);
endmodule

// File: rtl/qbp_sync.sv
// Two-flop synchroniser for asynchronous pad levels.
// Assumes: each bit is sampled on its own; multi-bit coherence is not needed.
module qbp_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta;

    // Two register stages; reset to the idle-high pad level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '1;
            q    <= '1;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/qbp_port.sv
// Drive sequencer for a bank of quasi-bidirectional pins: latch, boost timers,
// enable decode and the read path.
// Assumes: clk is the oscillator clock; pad_in is asynchronous to it.
module qbp_port #(
    parameter int              WIDTH     = 8,
    parameter int              PULSE_LEN = 2,
    parameter qbp_pkg::rd_src_e READ_SRC = qbp_pkg::RD_LATCH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] rd_data,
    output logic [WIDTH-1:0] drv_low,
    output logic [WIDTH-1:0] drv_high,
    output logic [WIDTH-1:0] keep_high
);
    localparam int RUN_W = $clog2(PULSE_LEN + 2);

    logic [WIDTH-1:0] lat_q, rise_req, clr_req, boost, pad_sync, read_val;

    qbp_latch #(.WIDTH(WIDTH)) u_latch (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .lat_q(lat_q), .rise_req(rise_req), .clr_req(clr_req)
    );

    qbp_sync #(.WIDTH(WIDTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        qbp_boost #(.PULSE_LEN(PULSE_LEN)) u_boost (
            .clk(clk), .rst_n(rst_n), .rise(rise_req[i]), .clr(clr_req[i]),
            .boost(boost[i])
        );

        // Counts consecutive strong-drive cycles, for the length check only.
        logic [RUN_W-1:0] run;
        always_ff @(posedge clk) begin
            if (!rst_n)                                run <= '0;
            else if (!drv_high[i])                     run <= '0;
            else if (run <= RUN_W'(PULSE_LEN))         run <= run + 1'b1;
        end

        // R11
        one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $countones({drv_low[i], drv_high[i], keep_high[i]}) == 1);
        // R2
        boost_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[i] && !lat_q[i]) |=> drv_high[i]);
        // R2
        boost_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
            drv_high[i] |-> (run < RUN_W'(PULSE_LEN)));
        // R5
        no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[i] && lat_q[i] && !drv_high[i]) |=> !drv_high[i]);
        // R7
        reset_quiet_chk: assert property (@(posedge clk)
            !rst_n |=> (!drv_high[i] && keep_high[i]));
    end

    // Decode the latch and the boost window into the three pad enables.
    always_comb begin
        drv_low   = ~lat_q;
        drv_high  = lat_q & boost;
        keep_high = lat_q & ~boost;
    end

    // Read source picked by the pin class, gated by the read select.
    always_comb begin
        read_val = (READ_SRC == qbp_pkg::RD_PAD) ? pad_sync : lat_q;
        rd_data  = rd_en ? read_val : '0;
    end
endmodule

// File: tb/qbp_port_test.sv
module qbp_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic rd_en = 1'b0;
    logic [W-1:0] pad_a = '0, pad_b = '1;
    logic [W-1:0] rd_a, low_a, high_a, keep_a;
    logic [W-1:0] rd_b, low_b, high_b, keep_b;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Latch-read bank, two-cycle boost.
    qbp_port #(.WIDTH(W), .PULSE_LEN(2), .READ_SRC(qbp_pkg::RD_LATCH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .pad_in(pad_a), .rd_data(rd_a),
        .drv_low(low_a), .drv_high(high_a), .keep_high(keep_a));

    // Pad-read bank, one-cycle boost.
    qbp_port #(.WIDTH(W), .PULSE_LEN(1), .READ_SRC(qbp_pkg::RD_PAD)) uut_pad (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .pad_in(pad_b), .rd_data(rd_b),
        .drv_low(low_b), .drv_high(high_b), .keep_high(keep_b));

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [W-1:0] v);
        wr_en = 1'b1;
        wr_data = v;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] rise;
        rd_en = 1'b1;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: reset state after release
        chk("R7", "high_a after reset", high_a, '0);
        chk("R7", "keep_a after reset", keep_a, '1);
        chk("R7", "rd_a latch after reset", rd_a, '1);
        chk("R7", "high_b after reset", high_b, '0);
        idle(1);
        chk("R7", "high_a one later", high_a, '0);

        // R1 R2 R3 R4 R5 R8: every old/new latch pair
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                do_write(W'(a));
                idle(3);
                pad_a = ~W'(b);
                do_write(W'(b));
                rise = ~W'(a) & W'(b);
                chk("R1", "low_a c1", low_a, ~W'(b));
                chk("R2", "high_a c1", high_a, rise);
                chk("R5", "keep_a c1", keep_a, W'(b) & ~rise);
                chk("R4", "high_b c1", high_b, rise);
                chk("R1", "low_b c1", low_b, ~W'(b));
                chk("R8", "rd_a latch", rd_a, W'(b));
                idle(1);
                chk("R2", "high_a c2", high_a, rise);
                chk("R4", "high_b c2", high_b, '0);
                chk("R3", "keep_b c2", keep_b, W'(b));
                idle(1);
                chk("R2", "high_a c3", high_a, '0);
                chk("R3", "keep_a c3", keep_a, W'(b));
            end
        end

        // R6: zero write cuts a boost short
        do_write('0);
        do_write('1);
        chk("R6", "high_a boosting", high_a, '1);
        do_write('0);
        chk("R6", "low_a after cut", low_a, '1);
        chk("R6", "high_a after cut", high_a, '0);
        idle(2);
        chk("R6", "high_a stays off", high_a, '0);

        // R9: pad reads take two edges
        for (int v = 0; v < (1 << W); v++) begin
            logic [W-1:0] prev;
            prev = rd_b;
            pad_b = W'(v);
            idle(1);
            chk("R9", "rd_b after one edge", rd_b, prev);
            idle(1);
            chk("R9", "rd_b after two edges", rd_b, W'(v));
        end

        // R10: read select low
        rd_en = 1'b0;
        #1;
        chk("R10", "rd_a deselected", rd_a, '0);
        chk("R10", "rd_b deselected", rd_b, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule